// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

An always-on controller that runs on a slow clock and drives a single power-enable output. Software turns power off by writing a shutdown command to the control word. The command takes effect only when the same write carries an 8-bit password. While power is off, the controller waits for an enabled wake-up source and then raises the output again.

There are three wake-up sources. The first is an external pin, which passes through a synchroniser and a debounce counter and can be set to wake on a high level, a low level, or a change from the level captured at shutdown. The other two are single-cycle event strobes from a real-time timer and a real-time clock, each with its own enable. A status word records which sources caused the wake-up and clears when it is read.

The register port is a simple single-cycle request interface. Writes take effect at the clock edge. Read data is combinational in the cycle of the request.

Top module: `shdn_wake_ctrl`

## Requirements
- R1: A write to byte offset 0x00 with bit 0 set and bits 31:24 equal to 0xA5 drops `pwr_en_o` on the clock edge that takes the write, while power is on.
- R2: A control write with bits 31:24 other than 0xA5, or with bit 0 clear, leaves `pwr_en_o` high. Reads of offset 0x00 and of unmapped offsets return zero.
- R3: The mode word at offset 0x04 stores all 32 written bits and reads them back unchanged. It is writable whether power is on or off. Its fields are: bits 2:0 pin mode (0 none, 1 high level, 2 low level, 3 change from the shutdown level, 4 to 7 none), bits 7:4 debounce count N, bit 16 timer enable, bit 17 clock enable.
- R4: The pin passes through two synchroniser stages. A pin wake-up fires only after the pin condition has held on N+1 consecutive synchronised samples. A pin change that is applied before clock edge k wakes the block on edge k+N+2, provided the pin stays put.
- R5: In change mode, the synchronised pin level is stored on the edge that accepts the shutdown. The wake condition is that the synchronised level differs from this stored value.
- R6: While power is off, `rtt_evt_i` wakes the block only when mode bit 16 is set, and `rtc_evt_i` wakes it only when mode bit 17 is set. The wake happens on the edge that samples the strobe.
- R7: `pwr_en_o` returns high on the first edge that sees an enabled wake-up while power is off. Wake-up inputs that arrive while power is on are ignored and set no status.
- R8: The status word at offset 0x08 has bit 0 for a pin wake, bit 16 for a timer wake and bit 17 for a clock wake. Every source that fires in the wake cycle is recorded. A read of the status word clears it at the edge of the read.
- R9: Out of reset, `pwr_en_o` is high, and the status word and mode word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | ADDR_W | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the request cycle |
| wake_pin_i | input | 1 | Asynchronous wake-up pin |
| rtt_evt_i | input | 1 | Real-time timer event strobe |
| rtc_evt_i | input | 1 | Real-time clock event strobe |
| pwr_en_o | output | 1 | Power enable, high when power is on |

## Verification
Results fall due at four different delays. A shutdown command or a timer or clock strobe changes `pwr_en_o` on the edge that samples it, so the bench checks the output at the following falling edge. A pin change is due N+3 edges after it is driven: two synchroniser stages plus N+1 qualifying samples. The bench checks that the output is still low one falling edge before that point and high at it. Read data is checked a short delay after the request is driven in the same cycle, and the clear-on-read effect is checked with a second read. A behavioural model that advances on every rising edge also predicts `pwr_en_o`, and the bench compares against it on every falling edge.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0] SHDN_KEY = 8'hA5;

  typedef enum logic [2:0] {
    PIN_OFF  = 3'd0,
    PIN_HIGH = 3'd1,
    PIN_LOW  = 3'd2,
    PIN_ANY  = 3'd3
  } pin_mode_e;

  typedef struct packed {
    logic [2:0] pin_mode;
    logic [3:0] deb_lim;
    logic       rtt_en;
    logic       rtc_en;
  } wake_cfg_t;

  // internal status order: [0] pin, [1] rtt, [2] rtc
  localparam int unsigned ST_PIN = 0;
  localparam int unsigned ST_RTT = 1;
  localparam int unsigned ST_RTC = 2;
  localparam int unsigned ST_W   = 3;
endpackage

// File: rtl/shdn_regs.sv
module shdn_regs
  import shdn_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ST_W-1:0]   status_i,
  output logic [DATA_W-1:0] rdata_o,
  output wake_cfg_t         cfg_o,
  output logic              shdn_cmd_o,
  output logic              status_rd_o
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8);

  logic [DATA_W-1:0] mode_q;
  logic hit_ctrl, hit_mode, hit_stat;

  assign hit_ctrl = req_i && (addr_i == OFF_CTRL);
  assign hit_mode = req_i && (addr_i == OFF_MODE);
  assign hit_stat = req_i && (addr_i == OFF_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mode_q <= '0;
    else if (hit_mode && we_i)  mode_q <= wdata_i;
  end

  assign shdn_cmd_o  = hit_ctrl && we_i && (wdata_i[31:24] == SHDN_KEY) && wdata_i[0];
  assign status_rd_o = hit_stat && !we_i;

  assign cfg_o.pin_mode = mode_q[2:0];
  assign cfg_o.deb_lim  = mode_q[7:4];
  assign cfg_o.rtt_en   = mode_q[16];
  assign cfg_o.rtc_en   = mode_q[17];

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_mode) rdata_o = mode_q;
      if (hit_stat) begin
        rdata_o[0]  = status_i[ST_PIN];
        rdata_o[16] = status_i[ST_RTT];
        rdata_o[17] = status_i[ST_RTC];
      end
    end
  end
endmodule

// File: rtl/shdn_pin_filter.sv
module shdn_pin_filter
  import shdn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             armed_i,
  input  logic             latch_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   ref_q;
  logic                   cond;
  logic [CNT_W-1:0]       cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ref_q <= 1'b0;
    else if (latch_i) ref_q <= synced;
  end

  always_comb begin
    unique case (mode_i)
      PIN_HIGH: cond = synced;
      PIN_LOW:  cond = !synced;
      PIN_ANY:  cond = synced ^ ref_q;
      default:  cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!(armed_i && cond))  cnt_q <= '0;
    else if (cnt_q < limit_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = armed_i && cond && (cnt_q >= limit_i);
endmodule

// File: rtl/shdn_power_seq.sv
module shdn_power_seq
  import shdn_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shdn_cmd_i,
  input  logic            pin_fire_i,
  input  logic            rtt_evt_i,
  input  logic            rtc_evt_i,
  input  wake_cfg_t       cfg_i,
  input  logic            status_rd_i,
  output logic            pwr_en_o,
  output logic            armed_o,
  output logic            latch_o,
  output logic [ST_W-1:0] status_o
);
  logic            pwr_q;
  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] wake_vec;

  assign armed_o = !pwr_q;
  assign latch_o = pwr_q && shdn_cmd_i;

  always_comb begin
    wake_vec         = '0;
    wake_vec[ST_PIN] = pin_fire_i;
    wake_vec[ST_RTT] = rtt_evt_i && cfg_i.rtt_en;
    wake_vec[ST_RTC] = rtc_evt_i && cfg_i.rtc_en;
    if (pwr_q) wake_vec = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pwr_q <= 1'b1;
    else if (pwr_q) pwr_q <= !shdn_cmd_i;
    else            pwr_q <= |wake_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_rd_i ? '0 : status_q) | wake_vec;
  end

  assign pwr_en_o = pwr_q;
  assign status_o = status_q;
endmodule

// File: rtl/shdn_wake_ctrl.sv
module shdn_wake_ctrl
  import shdn_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              wake_pin_i,
  input  logic              rtt_evt_i,
  input  logic              rtc_evt_i,
  output logic              pwr_en_o
);
  localparam int unsigned CNT_W = 4;

  wake_cfg_t       cfg;
  logic            shdn_cmd, status_rd, pin_fire, armed, latch;
  logic [ST_W-1:0] status_w;

  shdn_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (reg_req_i),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .status_i    (status_w),
    .rdata_o     (reg_rdata_o),
    .cfg_o       (cfg),
    .shdn_cmd_o  (shdn_cmd),
    .status_rd_o (status_rd)
  );

  shdn_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (wake_pin_i),
    .armed_i (armed),
    .latch_i (latch),
    .mode_i  (cfg.pin_mode),
    .limit_i (cfg.deb_lim),
    .fire_o  (pin_fire)
  );

  shdn_power_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shdn_cmd_i  (shdn_cmd),
    .pin_fire_i  (pin_fire),
    .rtt_evt_i   (rtt_evt_i),
    .rtc_evt_i   (rtc_evt_i),
    .cfg_i       (cfg),
    .status_rd_i (status_rd),
    .pwr_en_o    (pwr_en_o),
    .armed_o     (armed),
    .latch_o     (latch),
    .status_o    (status_w)
  );
endmodule

// File: rtl/shdn_wake_ctrl_chk.sv
module shdn_wake_ctrl_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rtt_i,
  input logic              rtt_en_i,
  input logic              pwr_en_i,
  input logic [2:0]        status_i
);
  logic ctrl_wr;
  assign ctrl_wr = req_i && we_i && (addr_i == ADDR_W'(0));

  p_shdn_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && ctrl_wr && wdata_i[31:24] == 8'hA5 && wdata_i[0]) |=> !pwr_en_i);

  p_bad_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && ctrl_wr && wdata_i[31:24] != 8'hA5) |=> pwr_en_i);

  p_timer_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_en_i && rtt_i && rtt_en_i) |=> (pwr_en_i && status_i[1]));

  p_no_capture_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && !(req_i && !we_i && addr_i == ADDR_W'(8))) |=> $stable(status_i));

  p_wake_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_i) |-> (status_i != 3'b000));

  p_status_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && req_i && !we_i && addr_i == ADDR_W'(8)) |=> (status_i == 3'b000));
endmodule

bind shdn_wake_ctrl shdn_wake_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (reg_req_i),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .rtt_i    (rtt_evt_i),
  .rtt_en_i (cfg.rtt_en),
  .pwr_en_i (pwr_en_o),
  .status_i (status_w)
);

// File: tb/shdn_wake_ctrl_test.sv
module shdn_wake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin = 1'b0, rtt = 1'b0, rtc = 1'b0;
  logic        pwr;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shdn_wake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .wake_pin_i(pin), .rtt_evt_i(rtt), .rtc_evt_i(rtc), .pwr_en_o(pwr)
  );

  // behavioural reference model
  bit        m_pwr;
  bit [31:0] m_mode, m_status;
  bit [1:0]  m_sync;
  bit        m_ref;
  int        m_cnt;
  bit        s_shut, s_syn, s_cond, s_pin, s_rtt, s_rtc, s_acc;
  int        s_lim;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 1; m_mode = 0; m_status = 0; m_sync = 0; m_ref = 0; m_cnt = 0;
    end else begin
      s_shut = !m_pwr;
      s_syn  = m_sync[1];
      s_lim  = int'(m_mode[7:4]);
      case (m_mode[2:0])
        3'd1: s_cond = s_syn;
        3'd2: s_cond = !s_syn;
        3'd3: s_cond = (s_syn != m_ref);
        default: s_cond = 0;
      endcase
      s_pin = s_shut && s_cond && (m_cnt >= s_lim);
      s_rtt = s_shut && rtt && m_mode[16];
      s_rtc = s_shut && rtc && m_mode[17];
      s_acc = !s_shut && req && we && addr == 4'h0 && wdata[31:24] == 8'hA5 && wdata[0];
      if (s_acc) m_ref = s_syn;
      if (s_shut && s_cond) begin
        if (m_cnt < s_lim) m_cnt++;
      end else m_cnt = 0;
      m_sync = {m_sync[0], pin};
      if (req && !we && addr == 4'h8) m_status = 0;
      if (s_pin) m_status[0] = 1;
      if (s_rtt) m_status[16] = 1;
      if (s_rtc) m_status[17] = 1;
      if (s_shut) m_pwr = s_pin || s_rtt || s_rtc;
      else if (s_acc) m_pwr = 0;
      if (req && we && addr == 4'h4) m_mode = wdata;
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // model comparison every cycle (R7)
  always @(negedge clk) if (rst_n && !done) check(32'(pwr), 32'(m_pwr), "R7 per-cycle pwr_en vs model");

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 check(rdata, exp, tag);
    @(negedge clk); req = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [31:0] SHDN = 32'hA500_0001;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check(32'(pwr), 1, "R9 pwr_en after reset");
    rd(4'h8, 0, "R9 status zero after reset");
    rd(4'h4, 0, "R9 mode zero after reset");
    // R3 full-word readback
    wr(4'h4, 32'hDEAD_0013);
    rd(4'h4, 32'hDEAD_0013, "R3 mode readback");
    // R2 bad key / bit0 clear
    wr(4'h4, 32'h0001_0000);
    wr(4'h0, 32'h5A00_0001);
    check(32'(pwr), 1, "R2 wrong key ignored");
    wr(4'h0, 32'hA500_0000);
    check(32'(pwr), 1, "R2 bit0 clear ignored");
    rd(4'h0, 0, "R2 control reads zero");
    // R1 accepted shutdown
    wr(4'h0, SHDN);
    check(32'(pwr), 0, "R1 shutdown accepted");
    // R6 disabled clock strobe ignored, timer wakes
    @(negedge clk); rtc = 1; @(negedge clk); rtc = 0;
    check(32'(pwr), 0, "R6 disabled rtc ignored");
    @(negedge clk); rtt = 1; @(negedge clk); rtt = 0;
    check(32'(pwr), 1, "R6 rtt wake");
    rd(4'h8, 32'h0001_0000, "R8 rtt status");
    rd(4'h8, 0, "R8 status cleared by read");
    // R7 events while on ignored
    @(negedge clk); rtt = 1; @(negedge clk); rtt = 0;
    check(32'(pwr), 1, "R7 pwr stays on");
    rd(4'h8, 0, "R7 no status while on");
    // R4 high level, N=3
    wr(4'h4, 32'h0000_0031);
    pin = 0; cyc(4);
    wr(4'h0, SHDN);
    @(negedge clk); pin = 1; cyc(3); pin = 0; cyc(8);
    check(32'(pwr), 0, "R4 short pulse filtered");
    pin = 1; cyc(5);
    check(32'(pwr), 0, "R4 not yet at N+2 edges");
    cyc(1);
    check(32'(pwr), 1, "R4 wake at N+3 edges");
    rd(4'h8, 32'h0000_0001, "R8 pin status");
    // R4 low level, N=0
    wr(4'h4, 32'h0000_0002);
    wr(4'h0, SHDN);
    @(negedge clk); pin = 0; cyc(2);
    check(32'(pwr), 0, "R4 low N=0 before due");
    cyc(1);
    check(32'(pwr), 1, "R4 low N=0 wake");
    rd(4'h8, 32'h0000_0001, "R8 pin status low");
    // R5 change mode, reference low
    wr(4'h4, 32'h0000_0023);
    cyc(3);
    wr(4'h0, SHDN);
    cyc(10);
    check(32'(pwr), 0, "R5 steady level no wake");
    pin = 1; cyc(5);
    check(32'(pwr), 1, "R5 change from low wakes");
    rd(4'h8, 32'h0000_0001, "R5 status");
    // R5 reference high
    cyc(3);
    wr(4'h0, SHDN);
    cyc(6);
    check(32'(pwr), 0, "R5 high ref holds");
    pin = 0; cyc(5);
    check(32'(pwr), 1, "R5 change from high wakes");
    rd(4'h8, 32'h0000_0001, "R5 status 2");
    // R3 reserved pin mode, mode written while off
    wr(4'h4, 32'h0000_0006);
    wr(4'h0, SHDN);
    pin = 1; cyc(6); pin = 0; cyc(6);
    check(32'(pwr), 0, "R3 reserved mode no pin wake");
    wr(4'h4, 32'h0001_0000);
    rd(4'h4, 32'h0001_0000, "R3 mode written while off");
    @(negedge clk); rtt = 1; @(negedge clk); rtt = 0;
    check(32'(pwr), 1, "R3 new mode effective while off");
    rd(4'h8, 32'h0001_0000, "R8 status after");
    // R8 simultaneous sources
    wr(4'h4, 32'h0003_0000);
    wr(4'h0, SHDN);
    @(negedge clk); rtt = 1; rtc = 1; @(negedge clk); rtt = 0; rtc = 0;
    check(32'(pwr), 1, "R6 rtc/rtt wake");
    rd(4'h8, 32'h0003_0000, "R8 both sources recorded");
    rd(4'h7, 0, "R2 unmapped reads zero");
    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule